// File: doc/BRIEF.md
# Elementary Angle Word Generator for a Word-Serial CORDIC

This block feeds the angle term of the z datapath in a word-serial, variable-precision circular CORDIC engine. Each coordinate is `16 * prec` bits wide, where `prec` is 1 to 8 words. The engine handles one 16-bit word per cycle, least significant word first. For each word cycle the caller presents the iteration index `i`, the word index and the precision one cycle ahead of use. One cycle later the block returns the matching word of the elementary angle.

The angle value is a fraction. Bit `n` would carry weight 1, with `n = 16 * prec`, so bit `n - 1` carries 2^-1. For early iterations (`3*i <= n`) the block forms an address into an external 512 x 16 angle ROM and passes the returned word through. The ROM holds every angle at the full 128-bit precision. A shorter precision reads only the upper words of each entry. For later iterations, atan(2^-i) equals 2^-i to within the working precision. The block then builds the word itself as a single set bit, so the ROM needs no entries beyond iteration 42.

Top module: `angle_word_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, and in the cycle after, `ang_valid` is 0 and `ang_word` is 0.
- R2: A request uses the ROM when `3*req_iter <= 16*req_prec`, and uses the generated pattern otherwise. The boundary is `i = floor(16*prec/3)`, which is ROM, and `i + 1`, which is generated.
- R3: In the cycle of a ROM-mode request, `rom_addr = req_iter*8 + (8 - req_prec) + req_word`. Word 0 of a ROM entry is the least significant word of the 128-bit angle.
- R4: One cycle after a ROM-mode request, `ang_word` equals `rom_data` in that cycle. The ROM has one cycle of read latency.
- R5: In the cycle of a generated-mode request or an idle cycle, `rom_addr` is 0.
- R6: One cycle after a generated-mode request with `i <= n`, `ang_word` has exactly one set bit when `req_word == (n-i) div 16`. That bit sits at position `(n-i) mod 16`. All other words are zero.
- R7: One cycle after a request with `i > n`, `ang_word` is 0.
- R8: `ang_valid` equals `req_valid` delayed by one cycle, and `ang_word` is 0 when `ang_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A word request is present this cycle |
| req_iter | input | 8 | CORDIC iteration index i |
| req_word | input | 3 | Word index within the coordinate, 0 = least significant |
| req_prec | input | 4 | Precision in 16-bit words, 1 to 8 |
| rom_addr | output | 11 | Address to the external angle ROM |
| rom_data | input | 16 | ROM read data, valid one cycle after the address |
| ang_valid | output | 1 | Angle word valid |
| ang_word | output | 16 | Angle word for the request of the previous cycle |

## Verification
The assertions assume that a valid request always carries a precision from 1 to 8, a word index below that precision, and an iteration index no larger than 255. They also assume that the ROM answers any address with a registered read. The stimulus walks each precision it uses over every legal word index. It picks iteration indices around the table threshold, at and just beyond `n`, and inside the ROM range. It mixes back-to-back requests with idle gaps and never issues an out-of-range word or precision. The bench's ROM model returns a hashed function of the address, so a wrong address shows up as a wrong data word.

// File: rtl/cag_pkg.sv
// Package: shared sizing for the angle word generator.
// Assumes a 16-bit word and up to 8 words per coordinate.
package cag_pkg;
    localparam int WORD_W    = 16;
    localparam int MAX_WORDS = 8;
    localparam int ITER_W    = 8;
    localparam int ADDR_W    = 11;
endpackage

// File: rtl/cag_mode_sel.sv
// Mode selector and ROM address former.
// Decides between table lookup (3*i <= n) and generated 2^-i words.
// Forms the ROM address with the iteration in the high part and the
// precision-aligned word index in the low part.
// Assumes prec is 1..MAX_WORDS and word < prec whenever valid is high.
module cag_mode_sel #(
    parameter int WORD_W    = cag_pkg::WORD_W,
    parameter int MAX_WORDS = cag_pkg::MAX_WORDS,
    parameter int ITER_W    = cag_pkg::ITER_W,
    parameter int ADDR_W    = cag_pkg::ADDR_W,
    localparam int WSEL_W   = $clog2(MAX_WORDS),
    localparam int PREC_W   = $clog2(MAX_WORDS + 1),
    localparam int BIT_W    = $clog2(WORD_W),
    localparam int CMP_W    = ITER_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [ITER_W-1:0] iter,
    input  logic [WSEL_W-1:0] word,
    input  logic [PREC_W-1:0] prec,
    output logic              use_rom,
    output logic [ADDR_W-1:0] rom_addr
);
    localparam int AX_W = ITER_W + WSEL_W + 1;
    localparam int TABLE_DEPTH = 512;

    logic [CMP_W-1:0] n_bits;
    logic [CMP_W-1:0] three_i;
    logic [AX_W-1:0]  addr_full;
    logic [PREC_W-1:0] word_offset;

    // Threshold compare: table mode while three times i does not exceed n.
    always_comb begin
        n_bits  = CMP_W'({prec, {BIT_W{1'b0}}});
        three_i = CMP_W'({2'b00, iter}) + CMP_W'({1'b0, iter, 1'b0});
        use_rom = (three_i <= n_bits);
    end

    // Address forming: skip the low words a shorter precision drops.
    always_comb begin
        word_offset = PREC_W'(MAX_WORDS) - prec;
        addr_full   = AX_W'({iter, {WSEL_W{1'b0}}})
                    + AX_W'(word_offset)
                    + AX_W'(word);
        rom_addr    = (valid && use_rom) ? ADDR_W'(addr_full) : '0;
    end

    // R3
    rom_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && use_rom) |-> (rom_addr < ADDR_W'(TABLE_DEPTH)));

    // R3
    req_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (prec != '0 && prec <= PREC_W'(MAX_WORDS)
                   && PREC_W'(word) < prec));
endmodule

// File: rtl/cag_pow2_word.sv
// Generated-word source for late iterations.
// Produces word `word` of 2^-i in an n-bit fraction (bit n weighs 1).
// This is a single set bit at absolute position n-i, or all zeros
// when i > n or the word does not hold that bit.
// Assumes prec and word are in range; output is combinational.
module cag_pow2_word #(
    parameter int WORD_W    = cag_pkg::WORD_W,
    parameter int MAX_WORDS = cag_pkg::MAX_WORDS,
    parameter int ITER_W    = cag_pkg::ITER_W,
    localparam int WSEL_W   = $clog2(MAX_WORDS),
    localparam int PREC_W   = $clog2(MAX_WORDS + 1),
    localparam int BIT_W    = $clog2(WORD_W),
    localparam int CMP_W    = ITER_W + 2
) (
    input  logic [ITER_W-1:0] iter,
    input  logic [WSEL_W-1:0] word,
    input  logic [PREC_W-1:0] prec,
    output logic [WORD_W-1:0] gen_word
);
    logic [CMP_W-1:0] n_bits;
    logic [CMP_W-1:0] iter_x;
    logic [CMP_W-1:0] pos;
    logic             beyond;
    logic             hit;

    // Position decode: locate the set bit and test the current word.
    always_comb begin
        n_bits   = CMP_W'({prec, {BIT_W{1'b0}}});
        iter_x   = CMP_W'(iter);
        beyond   = (iter_x > n_bits);
        pos      = n_bits - iter_x;
        hit      = ((pos >> BIT_W) == CMP_W'(word));
        gen_word = (!beyond && hit) ? (WORD_W'(1) << pos[BIT_W-1:0]) : '0;
    end
endmodule

// File: rtl/angle_word_gen.sv
// Elementary angle word generator, top level.
// The caller presents a request one cycle before the word is needed.
// The ROM address leaves in the request cycle. One cycle later the ROM
// word, or the locally generated 2^-i word, appears on ang_word.
// Assumes an external ROM with exactly one cycle of read latency.
module angle_word_gen #(
    parameter int WORD_W    = cag_pkg::WORD_W,
    parameter int MAX_WORDS = cag_pkg::MAX_WORDS,
    parameter int ITER_W    = cag_pkg::ITER_W,
    parameter int ADDR_W    = cag_pkg::ADDR_W,
    localparam int WSEL_W   = $clog2(MAX_WORDS),
    localparam int PREC_W   = $clog2(MAX_WORDS + 1),
    localparam int BIT_W    = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ITER_W-1:0] req_iter,
    input  logic [WSEL_W-1:0] req_word,
    input  logic [PREC_W-1:0] req_prec,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [WORD_W-1:0] rom_data,
    output logic              ang_valid,
    output logic [WORD_W-1:0] ang_word
);
    logic              use_rom;
    logic [WORD_W-1:0] gen_word;
    logic              valid_q;
    logic              use_rom_q;
    logic [WORD_W-1:0] gen_word_q;

    cag_mode_sel #(
        .WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS),
        .ITER_W(ITER_W), .ADDR_W(ADDR_W)
    ) u_mode_sel (
        .clk(clk), .rst_n(rst_n), .valid(req_valid),
        .iter(req_iter), .word(req_word), .prec(req_prec),
        .use_rom(use_rom), .rom_addr(rom_addr)
    );

    cag_pow2_word #(
        .WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS), .ITER_W(ITER_W)
    ) u_pow2 (
        .iter(req_iter), .word(req_word), .prec(req_prec),
        .gen_word(gen_word)
    );

    // Alignment stage: hold mode and generated word while the ROM reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q    <= 1'b0;
            use_rom_q  <= 1'b0;
            gen_word_q <= '0;
        end else begin
            valid_q    <= req_valid;
            use_rom_q  <= req_valid && use_rom;
            gen_word_q <= req_valid ? gen_word : '0;
        end
    end

    // Output select: ROM word in table mode, generated word otherwise.
    always_comb begin
        ang_valid = valid_q;
        if (!valid_q)       ang_word = '0;
        else if (use_rom_q) ang_word = rom_data;
        else                ang_word = gen_word_q;
    end

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ang_valid);

    // R4
    rom_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && use_rom) |=> (ang_word == rom_data));

    // R5
    gen_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !use_rom) |-> (rom_addr == '0));

    // R6
    gen_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !use_rom) |=> $onehot0(ang_word));

    // R7
    beyond_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({2'b00, req_iter} > {req_prec, {BIT_W{1'b0}}}))
        |=> (ang_word == '0));
endmodule

// File: tb/angle_word_gen_bench.sv
`timescale 1ns/1ps
module angle_word_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_iter = '0;
    logic [2:0]  req_word = '0;
    logic [3:0]  req_prec = 4'd1;
    logic [10:0] rom_addr;
    logic [15:0] rom_data = '0;
    logic        ang_valid;
    logic [15:0] ang_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          v;
        logic [15:0] w;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    angle_word_gen u_angle_word_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_iter(req_iter), .req_word(req_word), .req_prec(req_prec),
        .rom_addr(rom_addr), .rom_data(rom_data),
        .ang_valid(ang_valid), .ang_word(ang_word)
    );

    function automatic logic [15:0] rom_fn(int a);
        return 16'((a * 40503 + 4660) & 16'hFFFF);
    endfunction

    // ROM model with one cycle of read latency
    always @(posedge clk) rom_data <= rom_fn(int'(rom_addr));

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Driver: present one request or idle cycle and push its expectation
    task automatic drive(bit v, int i, int w, int p);
        exp_t e;
        int n = 16 * p;
        int exp_addr = 0;
        string tag;
        @(negedge clk);
        req_valid = v;
        req_iter  = 8'(i);
        req_word  = 3'(w);
        req_prec  = 4'(p);
        e.v = v;
        e.w = '0;
        if (v && 3 * i <= n) begin
            exp_addr = i * 8 + (8 - p) + w;
            e.w = rom_fn(exp_addr);
            tag = (3 * (i + 1) > n) ? "R2" : "R4";
        end else if (v && i > n) begin
            tag = "R7";
        end else if (v) begin
            if (w == (n - i) / 16) e.w = 16'(1) << ((n - i) % 16);
            tag = (3 * (i - 1) <= n) ? "R2" : "R6";
        end else begin
            tag = "R8";
        end
        e.req = tag;
        #1;
        if (v && 3 * i <= n)
            check(rom_addr == 11'(exp_addr), "R3", "rom_addr", int'(rom_addr), exp_addr);
        else
            check(rom_addr == 11'd0, "R5", "rom_addr", int'(rom_addr), 0);
        exp_q.push_back(e);
    endtask

    // Monitor: compare outputs just after each active edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check(ang_valid == e.v, "R8", "ang_valid", int'(ang_valid), int'(e.v));
                check(ang_word == e.w, e.req, "ang_word", int'(ang_word), int'(e.w));
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int plist[4] = '{1, 2, 5, 8};
        repeat (3) @(negedge clk);
        #1;
        check(ang_valid == 1'b0, "R1", "ang_valid in reset", int'(ang_valid), 0);
        check(ang_word == 16'd0, "R1", "ang_word in reset", int'(ang_word), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(ang_valid == 1'b0, "R1", "ang_valid after reset", int'(ang_valid), 0);
        drive(1'b0, 0, 0, 1);
        foreach (plist[k]) begin
            int p = plist[k];
            int n = 16 * p;
            int th = n / 3;
            int ilist[9] = '{0, 1, th, th + 1, th + 2, n - 17, n - 1, n, n + 3};
            foreach (ilist[j]) begin
                int i = ilist[j];
                if (i < 0) continue;
                for (int w = 0; w < p; w++) drive(1'b1, i, w, p);
                if (j % 3 == 0) drive(1'b0, 0, 0, p);
            end
        end
        // interleaved precisions back to back (R2, R4, R6)
        drive(1'b1, 5, 0, 8);
        drive(1'b1, 100, 1, 8);
        drive(1'b1, 2, 0, 1);
        drive(1'b1, 6, 0, 1);
        drive(1'b1, 17, 0, 1);
        repeat (3) drive(1'b0, 0, 0, 4);
        while (exp_q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule